// File: doc/BRIEF.md
# Register readback output multiplexer

This block keeps the configuration registers of a sampling converter and lets any of them be read back on the converter's own 12-bit parallel output bus. Registers are written through a simple address/data write port that stands in for a serial interface. In normal operation the output bus carries the ADC sample stream, registered on the sample clock.

A control register at address 23 selects readback. When its enable bit is set, the 10-bit register value chosen by its select field replaces the upper ten bits of the bus, and the two low bits are driven to zero. The select field works on two levels. A 3-bit upper part picks one of seven internal calibration-state values, which arrive as plain inputs. Only when that upper part is zero does a 6-bit lower part address the configuration bank.

The sample stream keeps feeding the calibration path during readback, through an output of its own. A write to address 63 clears the whole configuration bank, including the control register.

Top module: `readback_bus_mux`

## Requirements
- R1: While rst_ni is low, and just after it is released, every configuration register (including the control register) is 0 and data_o is 0.
- R2: When the control register's enable bit (bit 9) is 0, data_o equals the adc_data_i value from the previous clock edge, whatever the select field (bits 8..0) holds.
- R3: When the enable bit is 1, data_o[11:2] carries the selected 10-bit value and data_o[1:0] is 0.
- R4: When select bits 8..6 are 000, select bits 5..0 address the configuration bank. Addresses 0..22 and 62 store what wr_data_i brings when wr_en_i is high at a clock edge.
- R5: Addresses 24..61 hold no storage. Writes to them have no effect, and they read back as zero, as does address 63.
- R6: When select bits 8..6 are nonzero, bits 5..0 are ignored, and values 1..7 return, in that order: even average, odd average, even coarse DAC, odd coarse DAC, even fine DAC, odd fine DAC, gain.
- R7: cal_sample_o equals the adc_data_i value from the previous clock edge, whether or not readback is enabled.
- R8: Address 23 is the control register. Selecting it returns its own contents.
- R9: A write to address 63 sets every configuration register, including the control register, to 0 at the clock edge that captures the write.
- R10: Stored widths: addresses 0..3, 23 and 62 keep 10 bits; 4..15 keep bits 7..0; 16..22 keep bits 5..0. Bits above a register's width read back as 0.
- R11: A write to the control register changes data_o starting at the second clock edge after the write is presented. The edge that captures the write still uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 10 | Register write data |
| adc_data_i | input | 12 | ADC sample |
| cal_avg_even_i | input | 10 | Calibration state: even average |
| cal_avg_odd_i | input | 10 | Calibration state: odd average |
| cal_cdac_even_i | input | 10 | Calibration state: even coarse DAC |
| cal_cdac_odd_i | input | 10 | Calibration state: odd coarse DAC |
| cal_fdac_even_i | input | 10 | Calibration state: even fine DAC |
| cal_fdac_odd_i | input | 10 | Calibration state: odd fine DAC |
| cal_gain_i | input | 10 | Calibration state: gain |
| data_o | output | 12 | Output bus: samples or readback value |
| cal_sample_o | output | 12 | Sample stream to the calibration path |

## Verification
A sample presented before clock edge k appears on data_o and cal_sample_o after edge k. A register write presented before edge k is stored at edge k. A change to the control register therefore shows on data_o only after edge k+1, and the edge-k output is still formed from the old setting. The bench drives and samples on falling edges. Each write task returns on the falling edge after the capturing edge, and each readback check waits exactly one more rising edge before it samples. The latency and clear tests also check the intermediate cycle, where the old setting must still be visible.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int DATA_W   = 10;
  localparam int ADDR_W   = 6;
  localparam int ADC_W    = 12;
  localparam int NUM_CAL  = 7;
  localparam int ADDR_CTL = 23;
  localparam int ADDR_SPR = 62;
  localparam int ADDR_CLR = 63;

  function automatic bit has_storage(input int a);
    return (a <= ADDR_CTL) || (a == ADDR_SPR);
  endfunction

  function automatic int field_width(input int a);
    if (a <= 3 || a == ADDR_CTL || a == ADDR_SPR) return 10;
    else if (a <= 15) return 8;
    else return 6;
  endfunction

  function automatic logic [DATA_W-1:0] field_mask(input int a);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = (b < field_width(a));
    return m;
  endfunction
endpackage

// File: rtl/rb_cfg_bank.sv
module rb_cfg_bank
  import rb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  output logic [2**AW-1:0][DW-1:0]   bank_o,
  output logic [DW-1:0]              ctrl_o
);
  localparam int NREG = 2**AW;

  logic clr;
  assign clr = wr_en_i && (wr_addr_i == AW'(ADDR_CLR));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (has_storage(i)) begin : g_store
      localparam logic [DW-1:0] MASK = field_mask(i);
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= '0;
        else if (clr)                                 q <= '0;
        else if (wr_en_i && wr_addr_i == AW'(i))      q <= wr_data_i & MASK;
      end
      assign bank_o[i] = q;
    end else begin : g_empty
      assign bank_o[i] = '0;
    end
  end

  assign ctrl_o = bank_o[ADDR_CTL];
endmodule

// File: rtl/rb_sel_decode.sv
module rb_sel_decode
  import rb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NC = NUM_CAL
) (
  input  logic [DW-2:0]              sel_i,
  input  logic [2**AW-1:0][DW-1:0]   bank_i,
  input  logic [NC-1:0][DW-1:0]      cal_i,
  output logic [DW-1:0]              val_o
);
  localparam int GW = DW - 1 - AW;

  logic [GW-1:0] grp;
  logic [AW-1:0] idx;
  assign grp = sel_i[DW-2:AW];
  assign idx = sel_i[AW-1:0];

  always_comb begin
    val_o = '0;
    if (grp == '0) val_o = bank_i[idx];
    else begin
      for (int c = 0; c < NC; c++)
        if (int'(grp) == c + 1) val_o = cal_i[c];
    end
  end
endmodule

// File: rtl/rb_out_stage.sv
module rb_out_stage #(
  parameter int DW = 10,
  parameter int SW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rb_en_i,
  input  logic [DW-1:0] rb_val_i,
  input  logic [SW-1:0] adc_i,
  output logic [SW-1:0] bus_o,
  output logic [SW-1:0] cal_o
);
  localparam int PAD = SW - DW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o <= '0;
      cal_o <= '0;
    end else begin
      bus_o <= rb_en_i ? {rb_val_i, {PAD{1'b0}}} : adc_i;
      cal_o <= adc_i;
    end
  end
endmodule

// File: rtl/readback_bus_mux.sv
module readback_bus_mux
  import rb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int SW = ADC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [SW-1:0] adc_data_i,
  input  logic [DW-1:0] cal_avg_even_i,
  input  logic [DW-1:0] cal_avg_odd_i,
  input  logic [DW-1:0] cal_cdac_even_i,
  input  logic [DW-1:0] cal_cdac_odd_i,
  input  logic [DW-1:0] cal_fdac_even_i,
  input  logic [DW-1:0] cal_fdac_odd_i,
  input  logic [DW-1:0] cal_gain_i,
  output logic [SW-1:0] data_o,
  output logic [SW-1:0] cal_sample_o
);
  logic [2**AW-1:0][DW-1:0] bank;
  logic [DW-1:0]            rb_ctrl;
  logic [NUM_CAL-1:0][DW-1:0] cal_vec;
  logic [DW-1:0]            rb_val;

  // order fixes the select code 1..7
  assign cal_vec[0] = cal_avg_even_i;
  assign cal_vec[1] = cal_avg_odd_i;
  assign cal_vec[2] = cal_cdac_even_i;
  assign cal_vec[3] = cal_cdac_odd_i;
  assign cal_vec[4] = cal_fdac_even_i;
  assign cal_vec[5] = cal_fdac_odd_i;
  assign cal_vec[6] = cal_gain_i;

  rb_cfg_bank #(.AW(AW), .DW(DW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .bank_o    (bank),
    .ctrl_o    (rb_ctrl)
  );

  rb_sel_decode #(.AW(AW), .DW(DW), .NC(NUM_CAL)) u_dec (
    .sel_i  (rb_ctrl[DW-2:0]),
    .bank_i (bank),
    .cal_i  (cal_vec),
    .val_o  (rb_val)
  );

  rb_out_stage #(.DW(DW), .SW(SW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rb_en_i  (rb_ctrl[DW-1]),
    .rb_val_i (rb_val),
    .adc_i    (adc_data_i),
    .bus_o    (data_o),
    .cal_o    (cal_sample_o)
  );
endmodule

// File: rtl/rb_readback_chk.sv
module rb_readback_chk #(
  parameter int AW = 6,
  parameter int DW = 10,
  parameter int SW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [SW-1:0] adc_data_i,
  input logic [DW-1:0] cal_gain_i,
  input logic [DW-1:0] rb_ctrl_i,
  input logic [SW-1:0] data_o,
  input logic [SW-1:0] cal_sample_o
);
  // R2
  adc_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rb_ctrl_i[DW-1] |=> data_o == $past(adc_data_i));

  // R3
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_ctrl_i[DW-1] |=> data_o[SW-DW-1:0] == '0);

  // R6
  gain_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_ctrl_i[DW-1] && rb_ctrl_i[DW-2:AW] == '1) |=> data_o[SW-1:SW-DW] == $past(cal_gain_i));

  // R7
  cal_feed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> cal_sample_o == $past(adc_data_i));

  // R9
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '1) |=> rb_ctrl_i == '0);
endmodule

bind readback_bus_mux rb_readback_chk #(.AW(AW), .DW(DW), .SW(SW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .adc_data_i   (adc_data_i),
  .cal_gain_i   (cal_gain_i),
  .rb_ctrl_i    (rb_ctrl),
  .data_o       (data_o),
  .cal_sample_o (cal_sample_o)
);

// File: tb/readback_bus_mux_tb.sv
module readback_bus_mux_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [9:0]  wr_data_i = '0;
  logic [11:0] adc_data_i = '0;
  logic [9:0]  cal_v [7];
  logic [11:0] data_o, cal_sample_o;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_cfg [64];

  always #5 clk_i = ~clk_i;

  readback_bus_mux u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .adc_data_i,
    .cal_avg_even_i (cal_v[0]), .cal_avg_odd_i (cal_v[1]),
    .cal_cdac_even_i(cal_v[2]), .cal_cdac_odd_i(cal_v[3]),
    .cal_fdac_even_i(cal_v[4]), .cal_fdac_odd_i(cal_v[5]),
    .cal_gain_i     (cal_v[6]),
    .data_o, .cal_sample_o
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R10 widths
  function automatic logic [9:0] mask_of(input int a);
    if (a <= 3 || a == 23 || a == 62) return 10'h3FF;
    if (a >= 4 && a <= 15) return 10'h0FF;
    if (a >= 16 && a <= 22) return 10'h03F;
    return 10'h000;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [9:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [8:0] sel, output logic [11:0] v);
    wr(6'd23, {1'b1, sel});
    @(negedge clk_i);
    v = data_o;
  endtask

  task automatic t_reset();
    logic [11:0] v;
    check("R1 data_o in reset", data_o, 12'h000);
    @(negedge clk_i); rst_ni = 1'b1;
    check("R1 data_o after release", data_o, 12'h000);
    rd(9'd5, v);
    check("R1 reg5 zero", v, 12'h000);
    rd(9'd23, v);
    check("R1/R8 ctrl reads own value", v, {10'h217, 2'b00});
    wr(6'd23, 10'h000);
  endtask

  task automatic t_adc_pass();
    wr(6'd23, 10'h1C5); // enable 0, select nonzero
    for (int i = 0; i < 4; i++) begin
      logic [11:0] s;
      s = 12'hA5A ^ 12'(i * 273);
      adc_data_i = s;
      @(negedge clk_i);
      check("R2 ADC on bus while disabled", data_o, s);
    end
  endtask

  task automatic t_cfg_rw();
    int addrs [8] = '{0, 3, 4, 9, 15, 16, 22, 62};
    logic [11:0] v;
    foreach (addrs[k]) begin
      logic [9:0] d;
      d = 10'h3FF ^ 10'(addrs[k] * 37);
      wr(6'(addrs[k]), d);
      exp_cfg[addrs[k]] = d & mask_of(addrs[k]);
    end
    foreach (addrs[k]) begin
      rd(9'(addrs[k]), v);
      check("R4/R3 config readback", v, {exp_cfg[addrs[k]], 2'b00});
    end
    wr(6'd17, 10'h3FF);
    rd(9'd17, v);
    check("R10 6-bit zero-extended", v, {10'h03F, 2'b00});
    wr(6'd7, 10'h3FF);
    rd(9'd7, v);
    check("R10 8-bit zero-extended", v, {10'h0FF, 2'b00});
    exp_cfg[17] = 10'h03F; exp_cfg[7] = 10'h0FF;
  endtask

  task automatic t_undef();
    logic [11:0] v;
    wr(6'd40, 10'h2AB);
    rd(9'd40, v);
    check("R5 undefined addr 40 reads zero", v, 12'h000);
    rd(9'd61, v);
    check("R5 undefined addr 61 reads zero", v, 12'h000);
    rd(9'd63, v);
    check("R5 addr 63 reads zero", v, 12'h000);
    rd(9'd24, v);
    check("R5 undefined addr 24 reads zero", v, 12'h000);
  endtask

  task automatic t_cal();
    logic [11:0] v;
    adc_data_i = 12'hFFF;
    for (int g = 1; g <= 7; g++) begin
      rd({3'(g), 6'(g * 9)}, v);
      check("R6/R3 calibration select", v, {cal_v[g-1], 2'b00});
    end
  endtask

  task automatic t_cal_feed();
    rd(9'd0, data_o);
    for (int i = 0; i < 3; i++) begin
      logic [11:0] s;
      s = 12'h123 + 12'(i * 1000);
      adc_data_i = s;
      @(negedge clk_i);
      check("R7 cal feed during readback", cal_sample_o, s);
      check("R3 bus keeps readback", data_o, {exp_cfg[0], 2'b00});
    end
  endtask

  task automatic t_latency();
    wr(6'd23, 10'h000);
    adc_data_i = 12'h5C3;
    @(negedge clk_i);
    wr(6'd23, {1'b1, 9'd3});
    check("R11 capturing edge uses old setting", data_o, 12'h5C3);
    @(negedge clk_i);
    check("R11 next edge shows readback", data_o, {exp_cfg[3], 2'b00});
  endtask

  task automatic t_clear();
    logic [11:0] v;
    rd(9'd9, v);
    adc_data_i = 12'h6E1;
    wr(6'd63, 10'h155);
    check("R9 old setting at clear edge", data_o, {exp_cfg[9], 2'b00});
    @(negedge clk_i);
    check("R9 control cleared, ADC back", data_o, 12'h6E1);
    rd(9'd9, v);
    check("R9 reg9 cleared", v, 12'h000);
    rd(9'd62, v);
    check("R9 reg62 cleared", v, 12'h000);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (exp_cfg[i]) exp_cfg[i] = '0;
    cal_v[0] = 10'h155; cal_v[1] = 10'h2AA; cal_v[2] = 10'h0F1;
    cal_v[3] = 10'h30E; cal_v[4] = 10'h1B7; cal_v[5] = 10'h248;
    cal_v[6] = 10'h3C9;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_adc_pass();
    t_cfg_rw();
    t_undef();
    t_cal();
    t_cal_feed();
    t_latency();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule